// File: doc/BRIEF.md
# Five-Phase Synchronized Sine PWM Generator

This block drives the five half-bridges of a five-wire, five-phase stepper with sinusoidal pulse-width modulation. A single up-counting carrier sets the PWM period for every channel. A 32-bit phase accumulator moves forward by a programmable step once per carrier period. Five channel phases are taken from it, each 72 degrees from the next. The winding windings of such a motor are tied together, so every output must share the same carrier and change duty at the same instant.

Each channel looks up a signed sine sample from a full-circle table with a power-of-two depth. It scales the sample by an unsigned amplitude, rounds it, adds it to half of the period and clamps the result to a legal duty. The new duties are loaded only when the carrier wraps. When the amplitude is zero, all five channels sit at 50% duty and in phase, so the windings get no net drive. Software sets the step size and the amplitude through a small write port. A write does not change the period that is running.

Top module: `penta_sine_pwm`

## Requirements
- R1: While reset is held, all outputs are high, the carrier count is 0, the accumulator, step and amplitude are 0, and every duty is 32 of the 64-cycle period. The first period after reset therefore shows 32 high cycles on every channel.
- R2: One 6-bit carrier counts 0 to 63 and wraps. Each output is high exactly in the cycles where the count is below that channel's duty. All outputs therefore rise together at count 0, and each period shows one high run that starts at count 0.
- R3: When the amplitude used at a wrap is 0, all five duties loaded at that wrap are 32, whatever the phase.
- R4: Duty = 32 + floor((s*a + 2^17) / 2^18), clamped to the range 0 to 64. Here s is the signed 16-bit sine sample and a is the 8-bit amplitude (0 to 255).
- R5: The table has 256 entries. For index k, with t = k mod 128 and p = t*(128-t), the sample is m = floor(32767*16*p / (5*16384 - 4*p)). The sample is +m for k below 128 and -m otherwise.
- R6: Channel i (0 to 4) uses the phase acc + O_i mod 2^32, with O = 0x00000000, 0x33333333, 0x66666666, 0x9999999A, 0xCCCCCCCD. Its table index is bits 31:24 of that phase.
- R7: At each carrier wrap the accumulator adds the step word modulo 2^32, and it holds at all other times. The duties loaded at a wrap use the accumulator value from before that addition.
- R8: A write with wr_sel=0 loads the 32-bit step word, and a write with wr_sel=1 loads the amplitude from wr_data[7:0]. A write changes no output in the running period. It first shapes the duties loaded at the next wrap.
- R9: A duty never leaves 0 to 64. At amplitude 255, a sine peak gives a period that is high for all 64 cycles, and a sine trough gives a period with no high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the phase step word, 1 selects the amplitude |
| wr_data | input | 32 | Write data |
| pwm_o | output | 5 | PWM outputs, one per winding |

## Verification
The assertions check the following properties on every cycle:
- The carrier steps by one.
- The accumulator moves only at a wrap, and then by exactly the step word.
- Duties hold between wraps and stay inside the period.
- A zero amplitude forces half duty.
- A step write lands in its register.

Only the bench scenarios can show the rest. They measure the high time of every channel in every period against the sine, offset and rounding formulas. They cover the full-on and full-off ends at amplitude 255, accumulator wrap, sub-index step sizes, and a late write that must leave the running period untouched.

// File: rtl/penta_pwm_pkg.sv
package penta_pwm_pkg;
    localparam int NCH_DEF   = 5;
    localparam int PHW_DEF   = 32;
    localparam int TBL_AW    = 8;
    localparam int SMP_W     = 16;
    localparam int AMP_W     = 8;
    localparam int CNT_W_DEF = 6;

    // Phase offset of channel c among n evenly spaced channels, rounded to nearest.
    function automatic longint chan_offset(int c, int n, int w);
        return ((longint'(c) << w) * 2 + longint'(n)) / (2 * longint'(n));
    endfunction
endpackage

// File: rtl/pps_phase_tap.sv
module pps_phase_tap #(
    parameter int PHW = 32,
    parameter int AW  = 8,
    parameter logic [PHW-1:0] OFFSET = '0
) (
    input  logic [PHW-1:0] acc_i,
    output logic [AW-1:0]  idx_o
);
    // Table index comes from the top bits of the shifted phase.
    assign idx_o = AW'((acc_i + OFFSET) >> (PHW - AW));
endmodule

// File: rtl/pps_sine_rom.sv
module pps_sine_rom #(
    parameter int AW = 8,
    parameter int SW = 16
) (
    input  logic [AW-1:0]        idx_i,
    output logic signed [SW-1:0] smp_o
);
    localparam int DEPTH = 1 << AW;
    localparam int HALFD = DEPTH / 2;

    // Rational sine approximation, evaluated once per entry at elaboration.
    function automatic logic signed [SW-1:0] sine_at(int k);
        longint amax, t, p, mag;
        amax = (longint'(1) << (SW - 1)) - 1;
        t    = longint'(k % HALFD);
        p    = t * (longint'(HALFD) - t);
        mag  = (amax * 16 * p) / (5 * longint'(HALFD) * longint'(HALFD) - 4 * p);
        return (k < HALFD) ? SW'(mag) : SW'(-mag);
    endfunction

    logic signed [SW-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_tab
        assign table_q[i] = sine_at(i);
    end

    assign smp_o = table_q[idx_i];
endmodule

// File: rtl/pps_duty_scale.sv
module pps_duty_scale #(
    parameter int SW   = 16,
    parameter int AMPW = 8,
    parameter int CW   = 6
) (
    input  logic signed [SW-1:0] smp_i,
    input  logic [AMPW-1:0]      amp_i,
    output logic [CW:0]          duty_o
);
    localparam int PERIOD = 1 << CW;
    localparam int HALF   = PERIOD / 2;
    localparam int PW     = SW + AMPW + 1;
    localparam int SHIFT  = (SW - 1) + AMPW - (CW - 1);
    localparam int RW     = PW + 2;

    logic signed [PW-1:0] prod;
    logic signed [RW-1:0] rnd;
    logic signed [RW-1:0] ofs;
    logic signed [RW-1:0] sum;

    always_comb begin
        prod = PW'(smp_i * $signed({1'b0, amp_i}));
        rnd  = RW'(prod) + (RW'(1) <<< (SHIFT - 1));
        ofs  = rnd >>> SHIFT;
        sum  = ofs + RW'(HALF);
        if (sum < 0)
            duty_o = '0;
        else if (sum > RW'(PERIOD))
            duty_o = (CW + 1)'(PERIOD);
        else
            duty_o = sum[CW:0];
    end
endmodule

// File: rtl/penta_sine_pwm.sv
module penta_sine_pwm
    import penta_pwm_pkg::*;
#(
    parameter int NCH   = NCH_DEF,
    parameter int PHW   = PHW_DEF,
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic           wr_sel,
    input  logic [PHW-1:0] wr_data,
    output logic [NCH-1:0] pwm_o
);
    localparam int DUTY_W = CNT_W + 1;
    localparam int HALF   = (1 << CNT_W) / 2;

    typedef struct packed {
        logic [CNT_W-1:0]             cnt;
        logic [PHW-1:0]               acc;
        logic [PHW-1:0]               freq;
        logic [AMP_W-1:0]             amp;
        logic [NCH-1:0][DUTY_W-1:0]   duty;
    } state_t;

    localparam state_t RST_STATE = '{
        cnt:  '0,
        acc:  '0,
        freq: '0,
        amp:  '0,
        duty: {NCH{DUTY_W'(HALF)}}
    };

    state_t st_q, st_d;
    logic [NCH-1:0][DUTY_W-1:0] duty_new;

    // Per-channel lookup path: phase tap, sine table, amplitude scaling.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [TBL_AW-1:0]       idx;
        logic signed [SMP_W-1:0] smp;

        pps_phase_tap #(
            .PHW    (PHW),
            .AW     (TBL_AW),
            .OFFSET (PHW'(chan_offset(c, NCH, PHW)))
        ) u_tap (
            .acc_i (st_q.acc),
            .idx_o (idx)
        );

        pps_sine_rom #(
            .AW (TBL_AW),
            .SW (SMP_W)
        ) u_rom (
            .idx_i (idx),
            .smp_o (smp)
        );

        pps_duty_scale #(
            .SW   (SMP_W),
            .AMPW (AMP_W),
            .CW   (CNT_W)
        ) u_scale (
            .smp_i  (smp),
            .amp_i  (st_q.amp),
            .duty_o (duty_new[c])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_W'(1);
        if (wr_en) begin
            if (wr_sel)
                st_d.amp = wr_data[AMP_W-1:0];
            else
                st_d.freq = wr_data;
        end
        // Period boundary: load new duties, advance the phase.
        if (&st_q.cnt) begin
            st_d.duty = duty_new;
            st_d.acc  = st_q.acc + st_q.freq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= RST_STATE;
        else
            st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < NCH; i++)
            pwm_o[i] = {1'b0, st_q.cnt} < st_q.duty[i];
    end
endmodule

// File: rtl/penta_sine_pwm_chk.sv
module penta_sine_pwm_chk #(
    parameter int NCH    = 5,
    parameter int PHW    = 32,
    parameter int CNT_W  = 6,
    parameter int AMP_W  = 8,
    parameter int DUTY_W = 7
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_en,
    input logic                          wr_sel,
    input logic [PHW-1:0]                wr_data,
    input logic [CNT_W-1:0]              cnt_q,
    input logic [PHW-1:0]                acc_q,
    input logic [PHW-1:0]                freq_q,
    input logic [AMP_W-1:0]              amp_q,
    input logic [NCH-1:0][DUTY_W-1:0]    duty_q
);
    localparam int PERIOD = 1 << CNT_W;
    localparam int HALF   = PERIOD / 2;

    logic wrap;
    logic all_half;
    logic all_legal;

    always_comb begin
        wrap      = (cnt_q == {CNT_W{1'b1}});
        all_half  = 1'b1;
        all_legal = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            if (duty_q[i] != DUTY_W'(HALF))  all_half  = 1'b0;
            if (duty_q[i] >  DUTY_W'(PERIOD)) all_legal = 1'b0;
        end
    end

    a_r2_cnt_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

    a_r7_acc_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wrap)) |-> acc_q == PHW'($past(acc_q) + $past(freq_q)));

    a_r7_acc_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wrap)) |-> $stable(acc_q));

    a_r8_duty_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wrap)) |-> $stable(duty_q));

    a_r3_zero_amp: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wrap) && ($past(amp_q) == '0)) |-> all_half);

    a_r9_duty_range: assert property (@(posedge clk) disable iff (rst)
        all_legal);

    a_r8_step_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && !$past(wr_sel)) |-> freq_q == $past(wr_data));
endmodule

bind penta_sine_pwm penta_sine_pwm_chk #(
    .NCH    (NCH),
    .PHW    (PHW),
    .CNT_W  (CNT_W),
    .AMP_W  (penta_pwm_pkg::AMP_W),
    .DUTY_W (DUTY_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cnt_q   (st_q.cnt),
    .acc_q   (st_q.acc),
    .freq_q  (st_q.freq),
    .amp_q   (st_q.amp),
    .duty_q  (st_q.duty)
);

// File: tb/penta_sine_pwm_tb.sv
module penta_sine_pwm_tb;
    localparam int P = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [4:0]  pwm_o;

    penta_sine_pwm u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pwm_o   (pwm_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        int    duty [5];
        string tag;
    } exp_t;

    localparam logic [31:0] OFFS [5] = '{32'h0, 32'h33333333, 32'h66666666,
                                          32'h9999999A, 32'hCCCCCCCD};

    exp_t  sb [$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    run = 0;
    bit    done = 0;
    int    cur = 0;
    logic [31:0] m_acc = '0;
    logic [31:0] m_freq = '0;
    int    m_amp = 0;
    int    hi [5];
    bit    dropped [5];
    bit    bad [5];

    // R5 sample formula
    function automatic longint sine_ref(int k);
        longint t, p, m;
        t = longint'(k % 128);
        p = t * (128 - t);
        m = (longint'(32767) * 16 * p) / (5 * 16384 - 4 * p);
        return (k < 128) ? m : -m;
    endfunction

    // R4 and R6 duty expectation
    function automatic exp_t make_exp(logic [31:0] acc, int amp, string tag);
        exp_t e;
        for (int ch = 0; ch < 5; ch++) begin
            logic [31:0] ph;
            longint s, v;
            ph = acc + OFFS[ch];
            s  = sine_ref(int'(ph[31:24]));
            v  = 32 + ((s * amp + 131072) >>> 18);
            if (v < 0)  v = 0;
            if (v > 64) v = 64;
            e.duty[ch] = int'(v);
        end
        e.tag = tag;
        return e;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // Monitor: measures each channel's high time per period, pops and compares.
    always @(negedge clk) begin
        if (run) begin
            for (int ch = 0; ch < 5; ch++) begin
                if (pwm_o[ch]) begin
                    if (dropped[ch]) bad[ch] = 1'b1;
                    hi[ch]++;
                end else begin
                    dropped[ch] = 1'b1;
                end
            end
            if (cyc % P == P - 1) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R2", "no expected period queued", cyc / P, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    for (int ch = 0; ch < 5; ch++) begin
                        chk(hi[ch] == e.duty[ch], e.tag, $sformatf("period %0d ch%0d high cycles", cyc / P, ch),
                            hi[ch], e.duty[ch]);
                        chk(!bad[ch], "R2", $sformatf("period %0d ch%0d single run from count 0", cyc / P, ch),
                            int'(bad[ch]), 0);
                    end
                end
                for (int ch = 0; ch < 5; ch++) begin
                    hi[ch] = 0; dropped[ch] = 1'b0; bad[ch] = 1'b0;
                end
            end
        end
    end

    task automatic wr(bit sel, logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    endtask

    // Driver: optional writes at a slot in the current period, then queue the next period.
    task automatic step(int slot, bit wf, logic [31:0] f, bit wa, int a, string tag);
        do @(negedge clk); while (cyc != cur * P + slot);
        if (wf) begin wr(1'b0, f); m_freq = f; end
        if (wa) begin wr(1'b1, 32'(a)); m_amp = a; end
        sb.push_back(make_exp(m_acc, m_amp, tag));
        m_acc = m_acc + m_freq;
        cur++;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int ch = 0; ch < 5; ch++) begin
            hi[ch] = 0; dropped[ch] = 1'b0; bad[ch] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(pwm_o == 5'b11111, "R1", "outputs in reset", int'(pwm_o), 31);
        sb.push_back(make_exp(32'h0, 0, "R1"));
        @(posedge clk);
        #2 rst = 1'b0;
        run = 1'b1;

        step(5, 1, 32'h40000000, 0, 0, "R3");
        step(5, 0, 32'h0, 0, 0, "R8");
        step(P - 3, 0, 32'h0, 1, 255, "R4");
        step(5, 0, 32'h0, 0, 0, "R9");
        step(5, 0, 32'h0, 0, 0, "R4");
        step(5, 0, 32'h0, 0, 0, "R9");
        step(5, 1, 32'h01000000, 1, 128, "R6");
        step(5, 0, 32'h0, 0, 0, "R5");
        step(5, 0, 32'h0, 0, 0, "R5");
        step(5, 1, 32'h00800000, 0, 0, "R6");
        step(5, 0, 32'h0, 0, 0, "R5");
        step(5, 0, 32'h0, 0, 0, "R5");
        step(5, 1, 32'hF0000001, 1, 200, "R7");
        step(5, 0, 32'h0, 0, 0, "R7");
        step(5, 0, 32'h0, 0, 0, "R7");
        step(5, 0, 32'h0, 0, 0, "R8");
        step(5, 1, 32'h0A3D70A4, 1, 64, "R4");
        step(5, 0, 32'h0, 0, 0, "R4");
        step(P - 3, 1, 32'h12345678, 1, 0, "R3");
        step(5, 0, 32'h0, 0, 0, "R3");
        step(5, 0, 32'h0, 0, 0, "R3");

        wait (sb.size() == 0);
        @(negedge clk);
        run = 1'b0;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", sb.size(), 0);
            finish_run();
        end
    end
endmodule